// File: doc/BRIEF.md
# Periodic Tick Timer

This block produces a steady periodic tick for a processor system. The input clock goes through a fixed divide-by-16 prescaler. Each prescaled tick advances a 20-bit count. When the count reaches a programmed interval limit, it returns to zero and the period is complete. A 12-bit counter records how many periods have completed. Each completed period also raises a status flag, and that flag can drive an interrupt line.

Software reaches the block through a plain 32-bit register bus with an address, a write strobe, a read strobe, write data and read data. The current count state can be read through two addresses. One address acknowledges: reading it clears the flag and the period counter. The other address only looks and changes nothing. When software clears the run bit, the count does not stop at once. It keeps stepping until it returns to zero and then halts. Software can poll for a zero count to learn that the timer has stopped.

Top module: `tick_timer`

## Requirements
- R1: After reset, all registers read as zero, the prescaler is cleared and `irq_o` is low.
- R2: Offset 0x00 is the mode register. Bit 25 is the interrupt enable, bit 24 is the run bit, and bits 19:0 are the interval limit. All other bits are not stored and read as 0.
- R3: While the timer is active, the count steps by one once every 16 clock cycles. A count first written at a clock edge takes its first step at the 16th edge after that edge, and at no other edge in between.
- R4: On a prescaled tick where the count equals the interval limit, the count returns to 0, the period counter increments and the flag is set. One period therefore lasts limit+1 ticks.
- R5: `irq_o` is high exactly when the flag is set and the interrupt enable bit is 1.
- R6: A read at offset 0x08 returns the period counter in bits 31:20 and the count in bits 19:0. At the clock edge of the read, it clears the flag and sets the period counter to 0.
- R7: A read at offset 0x0C returns the same layout as offset 0x08 and changes no state.
- R8: If a period completes at the same edge as a read at offset 0x08, the flag stays set and the period counter becomes 1.
- R9: With the run bit clear, a nonzero count keeps stepping until it returns to zero, then stays at zero, and the prescaler holds.
- R10: The period counter wraps from 4095 to 0.
- R11: A read at offset 0x04 returns the flag in bit 0 and zeros in all other bits.
- R12: `bus_rdata` is zero in any cycle without a read strobe, and zero for an offset that maps to no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; the acknowledging side effect takes place at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address and the current state |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is an acknowledging read that lands on the exact clock edge where a period completes. Ticks occur only once every 16 cycles, and a wrap needs the count to sit at the limit. The directed part of the bench counts edges from the enabling write and places the read on the 96th edge. The random part keeps the limit at a small fixed value, so acknowledging reads collide with wraps many times. Wrapping the period counter takes 4096 periods with a limit of 0, which is a run of 65,536 cycles.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int unsigned TT_CNT_W  = 20;
  localparam int unsigned TT_PER_W  = 12;
  localparam int unsigned TT_PRE_W  = 4;
  localparam int unsigned TT_ADDR_W = 4;
  localparam int unsigned TT_IEN_BIT = 25;
  localparam int unsigned TT_RUN_BIT = 24;
  localparam logic [3:0] TT_OFF_MODE = 4'h0;
  localparam logic [3:0] TT_OFF_STAT = 4'h4;
  localparam logic [3:0] TT_OFF_ACK  = 4'h8;
  localparam logic [3:0] TT_OFF_PEEK = 4'hC;
endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
  parameter int unsigned PRE_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (PRE_W == 0) begin : g_nodiv
      assign tick = run;
    end else begin : g_div
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (!rst_n)   pre_q <= '0;
        else if (run) pre_q <= pre_q + 1'b1;
        else          pre_q <= '0;
      end
      assign tick = run && (pre_q == {PRE_W{1'b1}});
    end
  endgenerate
endmodule

// File: rtl/tt_core.sv
module tt_core #(
  parameter int unsigned CNT_W = 20,
  parameter int unsigned PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run_bit,
  input  logic [CNT_W-1:0] limit,
  input  logic             ack,
  output logic             active,
  output logic [CNT_W-1:0] cnt_q,
  output logic [PER_W-1:0] pcnt_q,
  output logic             flag_q
);
  logic wrap;

  assign active = run_bit || (cnt_q != '0);
  assign wrap   = tick && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pcnt_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wrap)      cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + 1'b1;

      if (wrap)     pcnt_q <= ack ? PER_W'(1) : pcnt_q + 1'b1;
      else if (ack) pcnt_q <= '0;

      if (wrap)     flag_q <= 1'b1;
      else if (ack) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tt_regs.sv
module tt_regs
  import tt_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned PER_W  = 12,
  localparam int unsigned DATA_W = CNT_W + PER_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [PER_W-1:0]  pcnt,
  input  logic              flag,
  output logic              mode_run,
  output logic              mode_ien,
  output logic [CNT_W-1:0]  mode_lim,
  output logic              ack_rd,
  output logic [DATA_W-1:0] bus_rdata
);
  logic sel_mode, sel_stat, sel_ack, sel_peek;
  logic [DATA_W-1:0] mode_word, stat_word, cnt_word;
  logic unused_wbits;

  assign sel_mode = (bus_addr == ADDR_W'(TT_OFF_MODE));
  assign sel_stat = (bus_addr == ADDR_W'(TT_OFF_STAT));
  assign sel_ack  = (bus_addr == ADDR_W'(TT_OFF_ACK));
  assign sel_peek = (bus_addr == ADDR_W'(TT_OFF_PEEK));
  assign ack_rd   = bus_rd && sel_ack;
  assign unused_wbits = ^bus_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_run <= 1'b0;
      mode_ien <= 1'b0;
      mode_lim <= '0;
    end else if (bus_wr && sel_mode) begin
      mode_run <= bus_wdata[TT_RUN_BIT];
      mode_ien <= bus_wdata[TT_IEN_BIT];
      mode_lim <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    mode_word = '0;
    mode_word[CNT_W-1:0] = mode_lim;
    mode_word[TT_RUN_BIT] = mode_run;
    mode_word[TT_IEN_BIT] = mode_ien;
    stat_word = '0;
    stat_word[0] = flag;
    cnt_word = {pcnt, cnt};
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (sel_mode)               bus_rdata = mode_word;
      else if (sel_stat)          bus_rdata = stat_word;
      else if (sel_ack || sel_peek) bus_rdata = cnt_word;
    end
  end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tt_pkg::*;
#(
  parameter int unsigned ADDR_W = TT_ADDR_W,
  parameter int unsigned CNT_W  = TT_CNT_W,
  parameter int unsigned PER_W  = TT_PER_W,
  parameter int unsigned PRE_W  = TT_PRE_W,
  localparam int unsigned DATA_W = CNT_W + PER_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  logic             tick, active, ack_rd;
  logic             mode_run, mode_ien, flag_q;
  logic [CNT_W-1:0] mode_lim, cnt_q;
  logic [PER_W-1:0] pcnt_q;

  tt_prescaler #(.PRE_W(PRE_W)) pre_i (
    .clk(clk), .rst_n(rst_n), .run(active), .tick(tick)
  );

  tt_core #(.CNT_W(CNT_W), .PER_W(PER_W)) core_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run_bit(mode_run),
    .limit(mode_lim), .ack(ack_rd), .active(active),
    .cnt_q(cnt_q), .pcnt_q(pcnt_q), .flag_q(flag_q)
  );

  tt_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PER_W(PER_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .cnt(cnt_q), .pcnt(pcnt_q),
    .flag(flag_q), .mode_run(mode_run), .mode_ien(mode_ien),
    .mode_lim(mode_lim), .ack_rd(ack_rd), .bus_rdata(bus_rdata)
  );

  assign irq_o = flag_q && mode_ien;
endmodule

// File: rtl/tt_checker.sv
module tt_checker #(
  parameter int unsigned CNT_W = 20,
  parameter int unsigned PER_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             ack_rd,
  input logic             mode_run,
  input logic             mode_ien,
  input logic [CNT_W-1:0] mode_lim,
  input logic [CNT_W-1:0] cnt_q,
  input logic [PER_W-1:0] pcnt_q,
  input logic             flag_q,
  input logic             irq_o
);
  // R3: the count holds between prescaled ticks
  a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
  // R3: a tick below the limit steps the count by one
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q != mode_lim) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
  // R4: a tick at the limit wraps the count and raises the flag
  a_r4_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == mode_lim) |=> (cnt_q == '0 && flag_q));
  // R5: the interrupt needs the enable bit
  a_r5_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> mode_ien);
  // R6: an acknowledging read with no wrap clears the flag and the period counter
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !(tick && cnt_q == mode_lim)) |=> (!flag_q && pcnt_q == '0));
  // R8: a wrap that collides with an acknowledge wins
  a_r8_wrap_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && tick && cnt_q == mode_lim) |=> (flag_q && pcnt_q == PER_W'(1)));
  // R9: a halted timer stays halted
  a_r9_stays_halted: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_run && cnt_q == '0) |=> (cnt_q == '0));
endmodule

bind tick_timer tt_checker #(.CNT_W(CNT_W), .PER_W(PER_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ack_rd(ack_rd),
  .mode_run(mode_run), .mode_ien(mode_ien), .mode_lim(mode_lim),
  .cnt_q(cnt_q), .pcnt_q(pcnt_q), .flag_q(flag_q), .irq_o(irq_o)
);

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  int ecount = 0;
  bit done = 1'b0;

  // reference state, built from the requirements
  logic        m_run, m_ien, m_flag;
  logic [19:0] m_lim, m_cnt;
  logic [11:0] m_pcnt;
  logic [3:0]  m_pre;
  logic        m_act, m_tk, m_wrap, m_ack;

  always #10 clk = ~clk;

  tick_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run <= 0; m_ien <= 0; m_flag <= 0; m_lim <= 0;
      m_cnt <= 0; m_pcnt <= 0; m_pre <= 0;
    end else begin
      m_act  = m_run || (m_cnt != 0);
      m_tk   = m_act && (m_pre == 4'hF);
      m_wrap = m_tk && (m_cnt == m_lim);
      m_ack  = bus_rd && (bus_addr == 4'h8);
      m_pre  <= m_act ? m_pre + 4'd1 : 4'd0;
      if (m_wrap) m_cnt <= 0;
      else if (m_tk) m_cnt <= m_cnt + 20'd1;
      if (m_wrap) m_pcnt <= m_ack ? 12'd1 : m_pcnt + 12'd1;
      else if (m_ack) m_pcnt <= 0;
      if (m_wrap) m_flag <= 1'b1;
      else if (m_ack) m_flag <= 1'b0;
      if (bus_wr && bus_addr == 4'h0) begin
        m_ien <= bus_wdata[25]; m_run <= bus_wdata[24]; m_lim <= bus_wdata[19:0];
      end
    end
  end

  function automatic logic [31:0] exp_rdata(input logic rd, input logic [3:0] a);
    if (!rd) return 32'h0;
    case (a)
      4'h0: return {6'b0, m_ien, m_run, 4'b0, m_lim};
      4'h4: return {31'b0, m_flag};
      4'h8, 4'hC: return {m_pcnt, m_cnt};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic rd, input logic [3:0] a);
    if (!rd) return "R12";
    case (a)
      4'h0: return "R2";
      4'h4: return "R11";
      4'h8: return "R6";
      4'hC: return "R7";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive, compare against the reference, optional literal, advance one edge
  task automatic drive(input logic w, input logic r, input logic [3:0] a,
                       input logic [31:0] d, input logic lit_en,
                       input logic [31:0] lit, input string lit_tag);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    #1;
    check(bus_rdata, exp_rdata(r, a), tag_of(r, a));
    check({31'b0, irq_o}, {31'b0, m_flag & m_ien}, "R5");
    if (lit_en) check(bus_rdata, lit, lit_tag);
    @(posedge clk);
    ecount++;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0;
  endtask

  task automatic idle_until(input int k);
    while (ecount < k) drive(0, 0, 4'h0, 0, 0, 0, "");
  endtask

  task automatic peek_lit(input logic [31:0] v, input string t);
    drive(0, 1, 4'hC, 0, 1, v, t);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    finish_run();
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check({31'b0, irq_o}, 32'h0, "R1");
    drive(0, 1, 4'h0, 0, 1, 32'h0, "R1");
    drive(0, 1, 4'h4, 0, 1, 32'h0, "R1");
    peek_lit(32'h0, "R1");
    // start: run and interrupt enable, limit 2
    drive(1, 0, 4'h0, 32'h0300_0002, 0, 0, "");
    ecount = 0;
    idle_until(15);
    peek_lit(32'h0000_0000, "R3 no step before 16th edge");
    peek_lit(32'h0000_0001, "R3 step at 16th edge");
    idle_until(47);
    drive(0, 1, 4'h4, 0, 1, 32'h0, "R4 flag before wrap");
    check({31'b0, irq_o}, 32'h1, "R5 irq after wrap");
    peek_lit(32'h0010_0000, "R4 wrap after limit+1 ticks");
    drive(1, 0, 4'h0, 32'h0100_0002, 0, 0, "");
    check({31'b0, irq_o}, 32'h0, "R5 irq masked");
    drive(0, 1, 4'h4, 0, 1, 32'h1, "R11 flag held while masked");
    drive(0, 1, 4'h8, 0, 1, 32'h0010_0000, "R6 ack read value");
    peek_lit(32'h0, "R6 period counter cleared");
    drive(0, 1, 4'h4, 0, 1, 32'h0, "R6 flag cleared");
    idle_until(95);
    drive(0, 1, 4'h8, 0, 1, 32'h0000_0002, "R8 ack on wrap edge");
    peek_lit(32'h0010_0000, "R8 period counter is one");
    drive(0, 1, 4'h4, 0, 1, 32'h1, "R8 flag stays set");
    peek_lit(32'h0010_0000, "R7 peek has no side effect");
    idle_until(112);
    drive(1, 0, 4'h0, 32'h0000_0002, 0, 0, "");
    idle_until(143);
    peek_lit(32'h0010_0002, "R9 still counting after disable");
    peek_lit(32'h0020_0000, "R9 wrapped to zero");
    idle_until(200);
    peek_lit(32'h0020_0000, "R9 stays halted");
    drive(0, 1, 4'h2, 0, 1, 32'h0, "R12 unmapped offset");
    // R10: limit 0, one period per 16 cycles
    drive(0, 1, 4'h8, 0, 0, 0, "");
    drive(1, 0, 4'h0, 32'h0100_0000, 0, 0, "");
    ecount = 0;
    idle_until(16 * 4095);
    peek_lit(32'hFFF0_0000, "R10 counter at 4095");
    idle_until(16 * 4096);
    peek_lit(32'h0000_0000, "R10 counter wrapped");
    // R2: unused bits not stored
    drive(1, 0, 4'h0, 32'hFFFF_FFFF, 0, 0, "");
    drive(0, 1, 4'h0, 0, 1, 32'h030F_FFFF, "R2 mode layout");
    drive(1, 0, 4'h0, 32'h0300_0005, 0, 0, "");
    // random phase against the reference
    for (int i = 0; i < 30000; i++) begin
      int unsigned p;
      p = $urandom_range(99);
      if (p < 3)
        drive(1, 0, 4'h0, {6'b0, 2'($urandom_range(3)), 4'b0, 20'd5}, 0, 0, "");
      else if (p < 40)
        drive(0, 1, 4'($urandom_range(3) * 4), 0, 0, 0, "");
      else
        drive(0, 0, 4'h0, 0, 0, 0, "");
    end
    finish_run();
  end
endmodule